// File: doc/BRIEF.md
# Power-Down and Reset Sequencer

This block manages the power-down/reset input of a laser driver and what happens after its supply comes up. It synchronizes an active-high power-down/reset pin, a supply-good level and a low-transmit-power fault level to the local clock. While the pin is held high, the block switches off the modulation and bias current reference enables. It also keeps the low-transmit-power fault away from the shutdown output, both during the pulse and for a fixed initialization window after it.

A pin pulse that lasts at least `MIN_PW` synchronized cycles counts as a reset event. When the pin falls after such a pulse, the enables come back at once and an initialization window of `INIT_CYC` cycles starts. When the window ends, the fault path is unmasked and a sticky reset-done flag is raised. Supply-up starts the same window, so a part that powers up with the pin high sees reset-done twice: once from the supply and once from the later pin release. The host must clear each of these with a one-cycle strobe.

The interrupt request combines reset-done, the fault-to-shutdown path and a vector of other fault flags with per-flag masks. It is held low for as long as the part is powered down. All ports are plain control and status levels, so the block has no streaming interface and no back-pressure.

Top module: `pwr_rst_seq`

## Requirements
- R1: With `rst_n` low, or with `supply_ok` low, and after the synchronizer has settled, `mod_en`, `bias_en`, `txp_trip`, `rst_done` and `irq` are all 0.
- R2: With the supply up, `mod_en` and `bias_en` go to 0 no later than 3 cycles after `pd_rst_pin` rises. They return to 1 no later than 3 cycles after the pin falls, without waiting for the initialization window to end.
- R3: A pin-high period of fewer than `MIN_PW` synchronized cycles is not a reset event: it starts no initialization window and never sets `rst_done`. A period of at least `MIN_PW` cycles is a reset event.
- R4: `txp_trip` stays 0 while the synchronized pin is high, and also from the pin's fall until the initialization window ends, whatever `low_txp_flt` does.
- R5: After the window has ended, a high `low_txp_flt` drives `txp_trip` to 1 three cycles later.
- R6: `rst_done` rises exactly `INIT_CYC`+3 cycles after a qualified pin fall or a supply rise. It then stays at 1 until a cycle in which `host_clr` is 1.
- R7: If a `host_clr` strobe arrives in the same cycle that reset-done is being set, the flag ends up set.
- R8: `irq` is never 1 while the part is held in power-down. In particular, it stays 0 once the pin has been high for 4 cycles.
- R9: If the supply comes up while the pin is high, the enables stay at 0. `rst_done` is set once after the supply window and once more after the later qualified pin fall, and each setting needs its own clear. If the supply stays up and the pin stays low, no further setting happens.
- R10: Outside power-down, `irq` is the OR of `rst_done`, `txp_trip` and those `flt_flags` bits whose `flt_mask` bit is 0 (a mask bit of 1 blocks its flag). It is registered, so it follows one cycle after its sources.
- R11: When the supply drops, all outputs and `rst_done` are cleared; the flag does not survive a supply cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply-good level, asynchronous |
| pd_rst_pin | input | 1 | Active-high power-down/reset pin, asynchronous |
| low_txp_flt | input | 1 | Low-transmit-power fault level, asynchronous |
| flt_flags | input | N_FLT | Other fault flags, synchronous |
| flt_mask | input | N_FLT | Per-flag interrupt mask, 1 = blocked |
| host_clr | input | 1 | One-cycle strobe that clears reset-done |
| mod_en | output | 1 | Modulation current reference enable |
| bias_en | output | 1 | Bias current reference enable |
| txp_trip | output | 1 | Masked low-power fault to the shutdown path |
| rst_done | output | 1 | Sticky reset-done flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bound checker watches the following properties on every cycle:
- the interrupt and the enables stay low during power-down;
- the trip path stays silent while the initialization timer runs;
- reset-done is sticky and wins over a simultaneous clear;
- supply loss clears the block.

Other behaviours depend on an exact latency or a sequence of events, so only the bench scenarios can show them:
- the pulse-width qualification boundary at `MIN_PW`-1 versus `MIN_PW` cycles;
- the exact `INIT_CYC`+3 rise of reset-done;
- the double reset-done after a supply-up with the pin high;
- the per-flag masking of the interrupt.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  // events that start the initialization window
  typedef struct packed {
    logic sup_rise;
    logic pd_fall_ok;
  } prs_ev_t;

  function automatic logic prs_start(prs_ev_t ev);
    return ev.sup_rise | ev.pd_fall_ok;
  endfunction
endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/prs_pulse_qual.sv
module prs_pulse_qual #(
  parameter int MIN_PW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_s,
  input  logic pd_s,
  output logic pw_busy,
  output logic fall_ok
);
  localparam int CW = $clog2(MIN_PW + 1);
  localparam logic [CW-1:0] PW_MAX = CW'(MIN_PW);

  logic [CW-1:0] hi_cnt;

  // counts synchronized high cycles, saturating at MIN_PW
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_cnt <= '0;
    else if (!sup_s || !pd_s) hi_cnt <= '0;
    else if (hi_cnt != PW_MAX) hi_cnt <= hi_cnt + 1'b1;
  end

  // nonzero count while pin low marks the fall cycle
  assign pw_busy = (hi_cnt != '0);
  assign fall_ok = !pd_s && (hi_cnt >= PW_MAX);
endmodule

// File: rtl/prs_init_timer.sv
module prs_init_timer #(
  parameter int INIT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_s,
  input  logic load,
  output logic busy,
  output logic done_pulse
);
  localparam int TW = $clog2(INIT_CYC + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(INIT_CYC);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (!sup_s)         remain <= '0;
    else if (load)           remain <= T_LOAD;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy       = (remain != '0);
  assign done_pulse = (remain == TW'(1)) && !load;
endmodule

// File: rtl/prs_out_stage.sv
module prs_out_stage #(
  parameter int N_FLT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_s,
  input  logic             pd_s,
  input  logic             masked,
  input  logic             low_s,
  input  logic             done_pulse,
  input  logic             host_clr,
  input  logic [N_FLT-1:0] flt_flags,
  input  logic [N_FLT-1:0] flt_mask,
  output logic             en_q,
  output logic             trip_q,
  output logic             done_q,
  output logic             irq_q
);
  logic flt_any;
  assign flt_any = |(flt_flags & ~flt_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      trip_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (!sup_s) begin
      en_q   <= 1'b0;
      trip_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= !pd_s;
      trip_q <= low_s && !masked;
      done_q <= done_pulse || (done_q && !host_clr);  // set wins
      irq_q  <= !pd_s && (done_q || trip_q || flt_any);
    end
  end
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_pkg::*;
#(
  parameter int N_FLT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PW      = 8,
  parameter int INIT_CYC    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             pd_rst_pin,
  input  logic             low_txp_flt,
  input  logic [N_FLT-1:0] flt_flags,
  input  logic [N_FLT-1:0] flt_mask,
  input  logic             host_clr,
  output logic             mod_en,
  output logic             bias_en,
  output logic             txp_trip,
  output logic             rst_done,
  output logic             irq
);
  logic [2:0] raw_in, syn_out;
  logic       sup_s, pd_s, low_s, sup_q;
  logic       pw_busy, fall_ok, init_busy, done_pulse, masked, en_q;
  prs_ev_t    ev;

  assign raw_in = {supply_ok, pd_rst_pin, low_txp_flt};

  prs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_out)
  );
  assign {sup_s, pd_s, low_s} = syn_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sup_q <= 1'b0;
    else        sup_q <= sup_s;
  end

  prs_pulse_qual #(.MIN_PW(MIN_PW)) u_qual (
    .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .pd_s(pd_s),
    .pw_busy(pw_busy), .fall_ok(fall_ok)
  );

  assign ev.sup_rise   = sup_s && !sup_q;
  assign ev.pd_fall_ok = fall_ok;

  prs_init_timer #(.INIT_CYC(INIT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .load(prs_start(ev)),
    .busy(init_busy), .done_pulse(done_pulse)
  );

  // fault ignored from pin rise until the window closes
  assign masked = !sup_q || pd_s || pw_busy || init_busy;

  prs_out_stage #(.N_FLT(N_FLT)) u_out (
    .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .pd_s(pd_s), .masked(masked),
    .low_s(low_s), .done_pulse(done_pulse), .host_clr(host_clr),
    .flt_flags(flt_flags), .flt_mask(flt_mask),
    .en_q(en_q), .trip_q(txp_trip), .done_q(rst_done), .irq_q(irq)
  );

  assign mod_en  = en_q;
  assign bias_en = en_q;
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sup_s,
  input logic pd_s,
  input logic init_busy,
  input logic done_pulse,
  input logic host_clr,
  input logic mod_en,
  input logic bias_en,
  input logic txp_trip,
  input logic rst_done,
  input logic irq
);
  AST_PD_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd_s) |-> !irq);  // R8
  AST_PD_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd_s) |-> (!mod_en && !bias_en));  // R2
  AST_INIT_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_busy) |-> !txp_trip);  // R4
  AST_PD_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd_s) |-> !txp_trip);  // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_done && !host_clr && sup_s) |=> rst_done);  // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && sup_s) |=> rst_done);  // R7
  AST_SUPPLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_s |=> (!rst_done && !mod_en && !irq && !txp_trip));  // R11
endmodule

bind pwr_rst_seq pwr_rst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .pd_s(pd_s),
  .init_busy(init_busy), .done_pulse(done_pulse), .host_clr(host_clr),
  .mod_en(mod_en), .bias_en(bias_en), .txp_trip(txp_trip),
  .rst_done(rst_done), .irq(irq)
);

// File: tb/pwr_rst_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_rst_seq_tb_top;
  localparam int NF   = 4;
  localparam int MPW  = 4;
  localparam int INIT = 20;

  logic clk = 1'b0;
  logic rst_n, supply_ok, pd_rst_pin, low_txp_flt, host_clr;
  logic [NF-1:0] flt_flags, flt_mask;
  logic mod_en, bias_en, txp_trip, rst_done, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwr_rst_seq #(.N_FLT(NF), .SYNC_STAGES(2), .MIN_PW(MPW), .INIT_CYC(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_rst_pin(pd_rst_pin),
    .low_txp_flt(low_txp_flt), .flt_flags(flt_flags), .flt_mask(flt_mask),
    .host_clr(host_clr), .mod_en(mod_en), .bias_en(bias_en),
    .txp_trip(txp_trip), .rst_done(rst_done), .irq(irq)
  );

  // expected results
  function automatic logic held_down(logic [3:0] h);
    return &h;  // pin high for the last four drives
  endfunction
  function automatic logic exp_irq(logic done, logic trip, logic [NF-1:0] f, logic [NF-1:0] m);
    return done | trip | (|(f & ~m));
  endfunction
  function automatic int done_lat();
    return INIT + 3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_pulse();
    host_clr = 1'b1;
    step(1);
    host_clr = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [3:0] hist;
    void'($urandom(32'd2024));
    rst_n = 0; supply_ok = 0; pd_rst_pin = 0; low_txp_flt = 0;
    host_clr = 0; flt_flags = '0; flt_mask = '0;
    step(3);
    rst_n = 1;
    step(3);
    // R1 reset state
    chk("R1 outputs", {27'd0, mod_en, bias_en, txp_trip, rst_done, irq}, 32'd0);

    // supply-up with pin low, fault present during window
    supply_ok = 1; low_txp_flt = 1;
    step(done_lat() - 2);
    chk("R6 done not early", rst_done, 0);
    chk("R4 trip masked in supply window", txp_trip, 0);
    chk("R2 enables on", {mod_en, bias_en}, 2'b11);
    step(4);
    chk("R6 done after supply window", rst_done, 1);
    chk("R5 trip after window", txp_trip, 1);
    chk("R10 irq from done", irq, 1);
    low_txp_flt = 0;
    step(4);
    clr_pulse();
    step(2);
    chk("R6 cleared by strobe", rst_done, 0);
    chk("R10 irq low when idle", irq, 0);
    step(10);
    chk("R9 single done with pin low", rst_done, 0);

    // masked flags
    flt_flags = 4'b0101; flt_mask = 4'b0101;
    step(2);
    chk("R10 masked flags", irq, exp_irq(0, 0, 4'b0101, 4'b0101));
    flt_mask = 4'b0100;
    step(2);
    chk("R10 unmasked flag", irq, exp_irq(0, 0, 4'b0101, 4'b0100));
    flt_flags = '0; flt_mask = '0;
    step(2);

    // short pulse
    pd_rst_pin = 1;
    step(MPW - 1);
    chk("R2 enables off in pulse", {mod_en, bias_en}, 2'b00);
    pd_rst_pin = 0;
    step(done_lat() + 3);
    chk("R3 short pulse no done", rst_done, 0);
    chk("R2 enables back", {mod_en, bias_en}, 2'b11);

    // qualified pulse with fault held
    pd_rst_pin = 1;
    step(1);
    low_txp_flt = 1;
    step(MPW + 2);
    chk("R4 trip masked in pulse", txp_trip, 0);
    chk("R8 irq low in pulse", irq, 0);
    pd_rst_pin = 0;
    step(4);
    chk("R2 enables before window end", {mod_en, bias_en}, 2'b11);
    step(done_lat() - 6);
    chk("R4 trip masked in window", txp_trip, 0);
    chk("R3 done not yet", rst_done, 0);
    step(4);
    chk("R3 qualified pulse sets done", rst_done, 1);
    chk("R5 trip after pin window", txp_trip, 1);
    low_txp_flt = 0;
    clr_pulse();
    step(3);

    // clear coinciding with set
    pd_rst_pin = 1;
    step(MPW + 2);
    pd_rst_pin = 0;
    step(done_lat() - 1);
    clr_pulse();
    chk("R7 set wins over clear", rst_done, 1);
    step(2);

    // supply drop, then supply-up with pin high
    supply_ok = 0;
    step(4);
    chk("R11 supply drop clears", {28'd0, mod_en, txp_trip, rst_done, irq}, 32'd0);
    pd_rst_pin = 1;
    step(2);
    supply_ok = 1;
    step(done_lat() + 2);
    chk("R9 done from supply", rst_done, 1);
    chk("R9 enables stay off", {mod_en, bias_en}, 2'b00);
    chk("R8 irq low while held", irq, 0);
    clr_pulse();
    step(2);
    chk("R9 first clear", rst_done, 0);
    pd_rst_pin = 0;
    step(done_lat() + 2);
    chk("R9 second done", rst_done, 1);
    chk("R9 enables after release", {mod_en, bias_en}, 2'b11);
    clr_pulse();
    step(2);
    chk("R9 second clear", rst_done, 0);
    step(3 * INIT);
    chk("R9 no third done", rst_done, 0);

    // random phase
    hist = '0;
    for (int c = 0; c < 3000; c++) begin
      if (held_down(hist)) begin
        chk("R8 irq low in power-down", irq, 0);
        chk("R2 enables off in power-down", {mod_en, bias_en}, 2'b00);
        chk("R4 trip off in power-down", txp_trip, 0);
      end
      if (($urandom % 16) == 0) pd_rst_pin = ~pd_rst_pin;
      low_txp_flt = ($urandom % 4) == 0;
      flt_flags   = NF'($urandom);
      flt_mask    = NF'($urandom);
      host_clr    = ($urandom % 8) == 0;
      hist = {hist[2:0], pd_rst_pin};
      step(1);
    end

    finished = 1;
    report();
    $finish;
  end
endmodule